// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches page table entries next to a processor core and turns 32-bit virtual addresses into physical addresses. Pages are 4 KB. The low 12 bits of an address are the page offset, and the upper 20 bits are the virtual page number. That page number is compared against the tag of every stored entry at the same time. A lookup answers combinationally, in the cycle it is presented, with exactly one of three results:

- a hit, carrying the physical address;
- a protection fault;
- a miss.

The entry's side effects (referenced bit, modified bit, recency) are committed at the following clock edge.

After a miss, the logic outside the block walks the page table and writes the missing entry through the refill port. The buffer places the new entry in an empty slot if one exists. Otherwise it evicts the least recently used entry. Software changes protection on a page by invalidating that page's entry by page number. On a context switch it pulses the flush input, which empties the whole buffer.

Top module: `tlb_xlate`

## Requirements
- R1: On a permitted hit, `rsp_paddr` is the entry's 20-bit frame number concatenated with the unchanged low 12 address bits. It is given in the same cycle as the request, and `rsp_pte` shows the stored entry as it was before this access.
- R2: When `lk_valid` is high and no stored entry carries the request's page number (address bits 31:12) as its tag, only `rsp_miss` is high, and `rsp_paddr` and `rsp_pte` are zero.
- R3: An entry is 25 bits: bit 24 is valid, bit 23 is referenced, bit 22 is modified, bits 21:20 are protection and bits 19:0 are the frame number. A matching entry whose valid bit is 0 gives `rsp_fault` and no address.
- R4: The protection code 00 permits only read, 01 permits read and write, 10 permits only execute, and 11 permits all three. The access code is 00 read, 01 write, 10 execute; code 11 is never permitted. A forbidden access on a matching entry raises `rsp_fault` with `rsp_paddr` zero.
- R5: A permitted access sets the entry's referenced bit, and a permitted write also sets its modified bit. A faulting access changes neither bit. Both bits are visible in `rsp_pte` on a later lookup.
- R6: A refill stores the given page number and entry, so that a later lookup of that page number matches it.
- R7: A refill whose page number is already stored overwrites that entry instead of taking a second slot.
- R8: A refill of a new page number takes an empty slot whenever one exists, so no stored entry is evicted while space remains.
- R9: When the buffer is full, a refill of a new page number evicts the least recently used entry. An entry becomes most recently used when it is refilled, or when a lookup matches it (including a faulting lookup).
- R10: An invalidate removes only the entry tagged with the given page number. An invalidate of a page number that is not stored changes nothing.
- R11: A flush empties every entry, so every lookup in the cycles after it misses until a refill.
- R12: Flush overrides refill, and refill overrides invalidate, within a cycle. In any cycle with a flush, refill or invalidate request, a simultaneous lookup still reports its result, but its referenced, modified and recency updates are dropped.
- R13: While `lk_valid` is low, `rsp_hit`, `rsp_miss`, `rsp_fault`, `rsp_paddr` and `rsp_pte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_kind | input | 2 | Access type: 00 read, 01 write, 10 execute |
| rsp_hit | output | 1 | Permitted hit; address valid |
| rsp_miss | output | 1 | No entry for the page number |
| rsp_fault | output | 1 | Entry found but invalid or access forbidden |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_pte | output | 25 | Matched entry before this access, else zero |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Page number to refill |
| fill_pte | input | 25 | Entry to store |
| inv_en | input | 1 | Single-entry invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |
| flush | input | 1 | Empty every entry |

## Verification
Checks run on every cycle and cover the following:
- exactly one result per lookup, and silence when idle;
- the address offset passes through on a hit;
- no address is returned on a fault, and a hit is never given on a cleared valid bit;
- a write to a read-only page faults;
- after a refill the page no longer misses;
- after an invalidate the page misses;
- after a flush every lookup misses.

Only the bench's scenarios show the following:
- referenced and modified bits that appear on a later lookup;
- the choice of victim under least-recently-used order, and the preference for empty slots;
- overwrite of a page number that is already stored;
- the priority rules that drop a lookup's updates.

The bench checks these against a timestamp-ordered reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int PROT_W = 2;
  localparam int PTE_W  = 3 + PROT_W + PFN_W;
  localparam int V_BIT  = PTE_W - 1;
  localparam int R_BIT  = PTE_W - 2;
  localparam int M_BIT  = PTE_W - 3;
  localparam int PROT_LO = PFN_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PROT_RO  = 2'b00,
    PROT_RW  = 2'b01,
    PROT_XO  = 2'b10,
    PROT_RWX = 2'b11
  } prot_e;
endpackage

// File: rtl/tlb_enc.sv
module tlb_enc #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vec[i]) idx = idx | IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [PROT_W-1:0] prot,
  input  logic [1:0]        kind,
  output logic              allow
);
  always_comb begin
    unique case (kind)
      ACC_READ:  allow = (prot == PROT_RO) || (prot == PROT_RW) || (prot == PROT_RWX);
      ACC_WRITE: allow = (prot == PROT_RW) || (prot == PROT_RWX);
      ACC_EXEC:  allow = (prot == PROT_XO) || (prot == PROT_RWX);
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [DEPTH-1:0] used_vec,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age_q [DEPTH];
  logic [IDX_W-1:0] age_d [DEPTH];
  logic             found;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx) age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !used_vec[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (age_q[i] == IDX_W'(DEPTH - 1)) victim_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             flush_en,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_dirty,
  output logic [DEPTH-1:0] lk_vec,
  output logic [DEPTH-1:0] fill_vec,
  output logic [DEPTH-1:0] inv_vec,
  output logic [DEPTH-1:0] used_vec,
  output logic [PTE_W-1:0] lk_pte
);
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [VPN_W-1:0] tag_d [DEPTH];
  logic [PTE_W-1:0] pte_q [DEPTH];
  logic [PTE_W-1:0] pte_d [DEPTH];
  logic [DEPTH-1:0] used_q, used_d;
  logic             any_wr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_vec[g]   = used_q[g] && (tag_q[g] == lk_vpn);
    assign fill_vec[g] = used_q[g] && (tag_q[g] == fill_vpn);
    assign inv_vec[g]  = used_q[g] && (tag_q[g] == inv_vpn);
  end

  assign used_vec = used_q;

  always_comb begin
    lk_pte = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_vec[i]) lk_pte = lk_pte | pte_q[i];
    end
  end

  always_comb begin
    used_d = used_q;
    for (int i = 0; i < DEPTH; i++) begin
      tag_d[i] = tag_q[i];
      pte_d[i] = pte_q[i];
    end
    if (flush_en) begin
      used_d = '0;
    end else if (wr_en) begin
      tag_d[wr_idx]  = fill_vpn;
      pte_d[wr_idx]  = wr_pte;
      used_d[wr_idx] = 1'b1;
    end else if (clr_en) begin
      used_d[clr_idx] = 1'b0;
    end else if (upd_en) begin
      pte_d[upd_idx][R_BIT] = 1'b1;
      if (upd_dirty) pte_d[upd_idx][M_BIT] = 1'b1;
    end
  end

  assign any_wr = flush_en | wr_en | clr_en | upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        pte_q[i] <= '0;
      end
    end else if (any_wr) begin
      used_q <= used_d;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= tag_d[i];
        pte_q[i] <= pte_d[i];
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_kind,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PTE_W-1:0]  rsp_pte,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  logic [DEPTH-1:0] lk_vec, fill_vec, inv_vec, used_vec;
  logic [PTE_W-1:0] lk_pte;
  logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx, victim_idx, fill_tgt, touch_idx;
  logic             lk_any, fill_any, inv_any;
  logic             perm_ok, access_ok, side_op;
  logic             wr_en, clr_en, upd_en, upd_dirty, touch_en;

  tlb_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_enc_lk (
    .vec(lk_vec), .idx(lk_idx), .any(lk_any)
  );
  tlb_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_enc_fill (
    .vec(fill_vec), .idx(fill_idx), .any(fill_any)
  );
  tlb_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_enc_inv (
    .vec(inv_vec), .idx(inv_idx), .any(inv_any)
  );

  tlb_perm u_perm (
    .prot(lk_pte[PROT_LO +: PROT_W]), .kind(lk_kind), .allow(perm_ok)
  );

  always_comb begin
    access_ok = lk_pte[V_BIT] && perm_ok;
    rsp_hit   = lk_valid && lk_any && access_ok;
    rsp_fault = lk_valid && lk_any && !access_ok;
    rsp_miss  = lk_valid && !lk_any;
    rsp_paddr = rsp_hit ? {lk_pte[PFN_W-1:0], lk_off} : '0;
    rsp_pte   = (lk_valid && lk_any) ? lk_pte : '0;
  end

  always_comb begin
    side_op   = flush | fill_en | inv_en;
    fill_tgt  = fill_any ? fill_idx : victim_idx;
    wr_en     = fill_en && !flush;
    clr_en    = inv_en && inv_any && !flush && !fill_en;
    upd_en    = rsp_hit && !side_op;
    upd_dirty = (lk_kind == ACC_WRITE);
    touch_en  = !flush && (fill_en || (lk_valid && lk_any && !side_op));
    touch_idx = fill_en ? fill_tgt : lk_idx;
  end

  tlb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_q),
    .lk_vpn(lk_vpn), .fill_vpn(fill_vpn), .inv_vpn(inv_vpn),
    .wr_en(wr_en), .wr_idx(fill_tgt), .wr_pte(fill_pte),
    .clr_en(clr_en), .clr_idx(inv_idx),
    .flush_en(flush),
    .upd_en(upd_en), .upd_idx(lk_idx), .upd_dirty(upd_dirty),
    .lk_vec(lk_vec), .fill_vec(fill_vec), .inv_vec(inv_vec),
    .used_vec(used_vec), .lk_pte(lk_pte)
  );

  tlb_lru #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_q),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .used_vec(used_vec), .victim_idx(victim_idx)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [1:0]        lk_kind,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [PTE_W-1:0]  rsp_pte,
  input logic              fill_en,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic              inv_en,
  input logic [VPN_W-1:0]  inv_vpn,
  input logic              flush
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0 && rsp_pte == '0)); // R13

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R1

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0)); // R4

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pte[V_BIT]); // R3

  AST_RO_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == ACC_WRITE && rsp_pte[PROT_LO +: PROT_W] == PROT_RO && !rsp_miss)
      |-> rsp_fault); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_valid |-> rsp_miss)); // R11

  AST_INV_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en && !flush) |=>
      ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vpn)) |-> rsp_miss)); // R10

  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=>
      ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> !rsp_miss)); // R6
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_q),
  .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte),
  .fill_en(fill_en), .fill_vpn(fill_vpn),
  .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [24:0] rsp_pte;
  logic        fill_en;
  logic [19:0] fill_vpn;
  logic [24:0] fill_pte;
  logic        inv_en;
  logic [19:0] inv_vpn;
  logic        flush;

  always #10 clk = ~clk;

  tlb_xlate #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  bit          m_used  [DEPTH];
  logic [19:0] m_vpn   [DEPTH];
  logic [24:0] m_pte   [DEPTH];
  int          m_stamp [DEPTH];
  int          tick = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < DEPTH; i++)
      if (m_used[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic bit m_perm(input logic [1:0] prot, input logic [1:0] kind);
    case (kind)
      2'd0: return prot != 2'd2;
      2'd1: return prot == 2'd1 || prot == 2'd3;
      2'd2: return prot[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [24:0] mk_pte(input bit v, input logic [1:0] prot,
                                         input logic [19:0] pfn);
    return {v, 1'b0, 1'b0, prot, pfn};
  endfunction

  task automatic m_fill(input logic [19:0] v, input logic [24:0] p);
    int idx = m_find(v);
    if (idx < 0) begin
      for (int i = 0; i < DEPTH; i++)
        if (idx < 0 && !m_used[i]) idx = i;
    end
    if (idx < 0) begin
      idx = 0;
      for (int i = 1; i < DEPTH; i++)
        if (m_stamp[i] < m_stamp[idx]) idx = i;
    end
    m_used[idx] = 1'b1;
    m_vpn[idx]  = v;
    m_pte[idx]  = p;
    tick++;
    m_stamp[idx] = tick;
  endtask

  task automatic step(input bit lkv, input logic [31:0] va, input logic [1:0] kd,
                      input bit fen, input logic [19:0] fv, input logic [24:0] fp,
                      input bit ien, input logic [19:0] iv, input bit fl,
                      input string req);
    int idx;
    bit match, ok;
    logic [63:0] exp_v;
    @(negedge clk);
    lk_valid = lkv; lk_vaddr = va; lk_kind = kd;
    fill_en = fen; fill_vpn = fv; fill_pte = fp;
    inv_en = ien; inv_vpn = iv; flush = fl;
    #2;
    idx   = m_find(va[31:12]);
    match = lkv && (idx >= 0);
    ok    = 1'b0;
    exp_v = '0;
    if (match) begin
      ok = m_pte[idx][24] && m_perm(m_pte[idx][21:20], kd);
      exp_v[56:32] = m_pte[idx];
      if (ok) exp_v[31:0] = {m_pte[idx][19:0], va[11:0]};
    end
    exp_v[59] = ok;
    exp_v[58] = lkv && (idx < 0);
    exp_v[57] = match && !ok;
    check(req, "hit/miss/fault/pte/paddr",
          {4'b0, rsp_hit, rsp_miss, rsp_fault, rsp_pte, rsp_paddr}, exp_v);
    @(posedge clk);
    #1;
    if (fl) begin
      for (int i = 0; i < DEPTH; i++) m_used[i] = 1'b0;
    end else if (fen) begin
      m_fill(fv, fp);
    end else if (ien) begin
      int j = m_find(iv);
      if (j >= 0) m_used[j] = 1'b0;
    end else if (match) begin
      tick++;
      m_stamp[idx] = tick;
      if (ok) begin
        m_pte[idx][23] = 1'b1;
        if (kd == 2'd1) m_pte[idx][22] = 1'b1;
      end
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kd, input string req);
    step(1, va, kd, 0, '0, '0, 0, '0, 0, req);
  endtask
  task automatic refill(input logic [19:0] v, input logic [24:0] p, input string req);
    step(0, '0, 2'd0, 1, v, p, 0, '0, 0, req);
  endtask
  task automatic invalidate(input logic [19:0] v, input string req);
    step(0, '0, 2'd0, 0, '0, '0, 1, v, 0, req);
  endtask
  task automatic do_flush(input string req);
    step(0, '0, 2'd0, 0, '0, '0, 0, '0, 1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] pend;
    bit has_pend;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin
      m_used[i] = 0; m_vpn[i] = '0; m_pte[i] = '0; m_stamp[i] = 0;
    end
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = '0; lk_kind = '0;
    fill_en = 0; fill_vpn = '0; fill_pte = '0;
    inv_en = 0; inv_vpn = '0; flush = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state: R2 miss, R13 idle
    lookup(32'h0001_2345, 2'd0, "R2 reset");
    step(0, 32'h0001_2345, 2'd0, 0, '0, '0, 0, '0, 0, "R13 idle");

    // R1, R6, R5, R4 on a read-only page
    refill(20'h00012, mk_pte(1, 2'b00, 20'hABCDE), "R6");
    lookup(32'h0001_2345, 2'd0, "R1 read hit");
    @(negedge clk); #1;
    lookup(32'h0001_2FF0, 2'd0, "R5 referenced set");
    lookup(32'h0001_2004, 2'd1, "R4 write to read-only");
    lookup(32'h0001_2004, 2'd0, "R5 no dirty after fault");
    lookup(32'h0001_2004, 2'd3, "R4 reserved access code");

    // explicit frame concat check, R1
    @(negedge clk);
    lk_valid = 1; lk_vaddr = 32'h0001_2345; lk_kind = 2'd0;
    fill_en = 0; inv_en = 0; flush = 0;
    #2;
    check("R1", "paddr concat", {32'b0, rsp_paddr}, {32'b0, 32'hABCDE345});
    @(posedge clk); #1;
    tick++; m_stamp[m_find(20'h00012)] = tick;

    // R5 dirty on read-write page
    refill(20'h00020, mk_pte(1, 2'b01, 20'h11111), "R6");
    lookup(32'h0002_0ABC, 2'd1, "R5 permitted write");
    lookup(32'h0002_0ABC, 2'd0, "R5 modified visible");
    lookup(32'h0002_0ABC, 2'd2, "R4 exec on read-write");

    // R4 execute-only
    refill(20'h00030, mk_pte(1, 2'b10, 20'h33333), "R6");
    lookup(32'h0003_0010, 2'd0, "R4 read on exec-only");
    lookup(32'h0003_0010, 2'd2, "R4 exec on exec-only");
    refill(20'h00050, mk_pte(1, 2'b11, 20'h55555), "R6");
    lookup(32'h0005_0777, 2'd1, "R4 write on rwx");
    lookup(32'h0005_0777, 2'd2, "R4 exec on rwx");

    // R3 valid bit clear
    refill(20'h00040, mk_pte(0, 2'b11, 20'h44444), "R6");
    lookup(32'h0004_0000, 2'd0, "R3 invalid entry faults");
    step(0, 32'h0005_0777, 2'd1, 0, '0, '0, 0, '0, 0, "R13 idle with entries");

    // R10 invalidate
    invalidate(20'h00020, "R10");
    lookup(32'h0002_0ABC, 2'd0, "R10 removed");
    lookup(32'h0001_2345, 2'd0, "R10 neighbour kept");
    invalidate(20'h00999, "R10 absent");
    lookup(32'h0005_0777, 2'd0, "R10 absent no effect");

    // R12 priorities
    refill(20'h00070, mk_pte(1, 2'b01, 20'h77777), "R6");
    step(1, 32'h0007_0001, 2'd1, 1, 20'h00060, mk_pte(1, 2'b01, 20'h66666),
         0, '0, 0, "R12 lookup beside refill");
    lookup(32'h0007_0001, 2'd0, "R12 dropped update");
    step(0, '0, 2'd0, 1, 20'h00080, mk_pte(1, 2'b11, 20'h88888), 1, 20'h00070, 0,
         "R12 refill over invalidate");
    lookup(32'h0007_0001, 2'd0, "R12 invalidate lost");
    lookup(32'h0008_0001, 2'd0, "R12 refill taken");
    step(0, '0, 2'd0, 1, 20'h00090, mk_pte(1, 2'b11, 20'h99999), 0, '0, 1,
         "R12 flush over refill");
    lookup(32'h0009_0000, 2'd0, "R12 refill lost to flush");
    lookup(32'h0001_2345, 2'd0, "R11 flushed");
    lookup(32'h0005_0777, 2'd0, "R11 flushed");

    // R9 least recently used
    for (int k = 0; k < DEPTH; k++)
      refill(20'h00100 + 20'(k), mk_pte(1, 2'b11, 20'h0A000 + 20'(k)), "R8");
    lookup(32'h0010_0000, 2'd0, "R9 touch oldest");
    refill(20'h00140, mk_pte(1, 2'b11, 20'h0B000), "R9");
    lookup(32'h0010_1000, 2'd0, "R9 victim evicted");
    lookup(32'h0010_0000, 2'd0, "R9 touched kept");
    lookup(32'h0014_0000, 2'd0, "R9 new present");

    // R8 empty slot preferred
    invalidate(20'h00105, "R8");
    refill(20'h00141, mk_pte(1, 2'b11, 20'h0B001), "R8");
    lookup(32'h0010_2000, 2'd0, "R8 oldest survives");
    lookup(32'h0010_5000, 2'd0, "R8 invalidated gone");

    // R7 overwrite of present page
    refill(20'h00141, mk_pte(1, 2'b01, 20'h0C0C0), "R7");
    lookup(32'h0014_1abc, 2'd0, "R7 new frame");
    for (int k = 0; k < DEPTH; k++)
      lookup({20'h00100 + 20'(k), 12'h010}, 2'd0, "R7 no duplicate");
    lookup(32'h0014_0000, 2'd0, "R7 no duplicate");

    // R11 flush then empty
    do_flush("R11");
    for (int k = 0; k < 4; k++)
      lookup({20'h00100 + 20'(k), 12'h0}, 2'd0, "R11 empty after flush");

    // randomized traffic: R1 R4 R5 R6 R9 R10 R12
    has_pend = 0;
    pend = '0;
    for (int it = 0; it < 3000; it++) begin
      int r = int'($urandom % 100);
      logic [19:0] v = 20'h00200 + 20'($urandom % 24);
      logic [24:0] p = {($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                        2'($urandom), 20'($urandom)};
      if (has_pend && r < 70) begin
        refill(pend, p, "R6 random refill");
        has_pend = 0;
      end else if (r < 75) begin
        invalidate(v, "R10 random");
      end else if (r < 76) begin
        do_flush("R11 random");
      end else if (r < 81) begin
        step(1, {v, 12'($urandom)}, 2'($urandom), 1, 20'h00200 + 20'($urandom % 24),
             p, 0, '0, 0, "R12 random combo");
      end else begin
        logic [31:0] va = {v, 12'($urandom)};
        if (m_find(v) < 0) begin
          has_pend = 1;
          pend = v;
        end
        lookup(va, 2'($urandom), "R9 random lookup");
      end
    end

    @(negedge clk);
    lk_valid = 0; fill_en = 0; inv_en = 0; flush = 0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule